// File: doc/BRIEF.md
# Loop Integrator with Acquisition Sweep and Lock Detect

This block is the digital loop filter of a clock-recovery loop. It receives one early/late decision per cycle, qualified by a valid strobe, from a two-level phase detector. It folds each decision into a saturating signed integrator whose value is the control word for an external oscillator. It also runs the frequency hunt that comes before lock, and it reports whether the loop can be trusted.

While the external phase-lock flag is low, a fixed sweep step is added to the integrator every cycle. Each time the integrator reaches one of its limits, the sweep turns back. When the phase-lock flag is high, the sweep is gated off. If the integrator stays pinned at a limit for a run of consecutive cycles, the block decides that no data is present. The lock output is high only when phase lock is present and this no-data condition is absent.

Top module: `pll_lock_sweep`

## Requirements
- R1: While reset is active, and in the first cycle after it, the control word is 0, the sweep direction output is 1 (upward) and lock is 0. The sweep is enabled.
- R2: A cycle with pd_valid_i=1 and pd_early_i=1 adds +1 to the integrator. A cycle with pd_valid_i=1 and pd_early_i=0 adds −1. A cycle with pd_valid_i=0 adds nothing from the detector. The new value appears at the next rising clock edge.
- R3: The integrator is signed, 12 bits wide by default. It clamps at +2047 and at −2048 and never wraps.
- R4: The sweep enable is registered as the inverse of phase_lock_i. Raising phase_lock_i stops sweep steps from the second edge onward. With phase lock held and no valid decisions, the control word does not move.
- R5: While the sweep is enabled, +4 is added per cycle when the direction is up and −4 when it is down. This term is added together with the detector term, and the sum is clamped to the range.
- R6: While sweeping, an edge at which the integrator already holds +2047 with direction up sets the direction to down. An edge at which it holds −2048 with direction down sets the direction to up.
- R7: Once the integrator has been at a limit for 16 consecutive edges, no-data is declared and lock falls at the following edge.
- R8: Lock is the registered AND of phase_lock_i and no-data being absent. When phase_lock_i is low, lock is 0 one edge later.
- R9: No-data clears in the cycle the integrator leaves the limit, and lock returns at the next edge if phase lock is still present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_valid_i | input | 1 | Detector decision is valid this cycle |
| pd_early_i | input | 1 | 1 = early (step up), 0 = late (step down) |
| phase_lock_i | input | 1 | External phase-lock flag |
| ctrl_word_o | output | 12 | Signed integrator value (oscillator control) |
| sweep_up_o | output | 1 | Current sweep direction, 1 = up |
| lock_o | output | 1 | Loop lock indication |

## Verification
Two things can land on the integrator in the same cycle: a detector step and a sweep step. The sweep reversal can also land in the very cycle the sum is clamped. To provoke both, the bench drives a steady stream of early decisions while the sweep climbs, and steady late decisions while it descends. At the top the bench expects the word to sit at +2047 exactly on the edge where the direction turns. On the next edge it expects +2047−4+1. The same holds mirrored at −2048. A cycle model in the bench, built from the requirements, is compared with the outputs at every falling edge.

// File: rtl/pll_ls_pkg.sv
package pll_ls_pkg;

  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} sweep_dir_e;

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/pll_sweep_ctrl.sv
module pll_sweep_ctrl
  import pll_ls_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phase_lock_i,
  input  logic at_max_i,
  input  logic at_min_i,
  output logic sweep_on_o,
  output logic sweep_up_o
);

  logic       sweep_on_q;
  sweep_dir_e dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sweep_on_q <= 1'b1;
      dir_q      <= DIR_UP;
    end else begin
      sweep_on_q <= !phase_lock_i;
      if (sweep_on_q) begin
        if (dir_q == DIR_UP && at_max_i)        dir_q <= DIR_DOWN;
        else if (dir_q == DIR_DOWN && at_min_i) dir_q <= DIR_UP;
      end
    end
  end

  assign sweep_on_o = sweep_on_q;
  assign sweep_up_o = (dir_q == DIR_UP);

  AST_SWEEP_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_lock_i |=> !sweep_on_o); // R4
  AST_TURN_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweep_on_o && sweep_up_o && at_max_i) |=> !sweep_up_o); // R6
  AST_TURN_AT_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweep_on_o && !sweep_up_o && at_min_i) |=> sweep_up_o); // R6

endmodule

// File: rtl/pll_loop_integ.sv
module pll_loop_integ
  import pll_ls_pkg::*;
#(
  parameter int INT_W      = 12,
  parameter int SWEEP_STEP = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pd_valid_i,
  input  logic                    pd_early_i,
  input  logic                    sweep_on_i,
  input  logic                    sweep_up_i,
  output logic signed [INT_W-1:0] acc_o,
  output logic                    at_max_o,
  output logic                    at_min_o
);

  localparam int ACC_MAX = (2 ** (INT_W - 1)) - 1;
  localparam int ACC_MIN = -(2 ** (INT_W - 1));

  logic signed [INT_W-1:0] acc_q;
  int pd_term, sw_term, acc_nxt;

  always_comb begin
    pd_term = 0;
    if (pd_valid_i) pd_term = pd_early_i ? 1 : -1;
    sw_term = 0;
    if (sweep_on_i) sw_term = sweep_up_i ? SWEEP_STEP : -SWEEP_STEP;
    acc_nxt = clamp_int(int'(acc_q) + pd_term + sw_term, ACC_MIN, ACC_MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= INT_W'(acc_nxt);
  end

  assign acc_o    = acc_q;
  assign at_max_o = (int'(acc_q) == ACC_MAX);
  assign at_min_o = (int'(acc_q) == ACC_MIN);

  AST_STEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int'(acc_q) - int'($past(acc_q)) <= SWEEP_STEP + 1) &&
     (int'($past(acc_q)) - int'(acc_q) <= SWEEP_STEP + 1))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_valid_i && !sweep_on_i) |=> $stable(acc_q)); // R4
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_max_o && pd_valid_i && pd_early_i && !(sweep_on_i && !sweep_up_i)) |=> at_max_o); // R3

endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det #(
  parameter int NODATA_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic at_max_i,
  input  logic at_min_i,
  input  logic phase_lock_i,
  output logic lock_o
);

  localparam int CNT_W = $clog2(NODATA_CYC + 1);

  logic [CNT_W-1:0] sat_cnt_q;
  logic             at_lim, no_data, lock_q;

  assign at_lim  = at_max_i || at_min_i;
  assign no_data = at_lim && (sat_cnt_q == CNT_W'(NODATA_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sat_cnt_q <= '0;
      lock_q    <= 1'b0;
    end else begin
      if (!at_lim)                               sat_cnt_q <= '0;
      else if (sat_cnt_q != CNT_W'(NODATA_CYC))  sat_cnt_q <= sat_cnt_q + 1'b1;
      lock_q <= phase_lock_i && !no_data;
    end
  end

  assign lock_o = lock_q;

  AST_NODATA_DROPS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_data |=> !lock_o); // R7
  AST_NO_PLOCK_NO_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_lock_i |=> !lock_o); // R8
  AST_RELOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!at_lim && phase_lock_i) |=> lock_o); // R9

endmodule

// File: rtl/pll_lock_sweep.sv
module pll_lock_sweep #(
  parameter int INT_W      = 12,
  parameter int SWEEP_STEP = 4,
  parameter int NODATA_CYC = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pd_valid_i,
  input  logic                    pd_early_i,
  input  logic                    phase_lock_i,
  output logic signed [INT_W-1:0] ctrl_word_o,
  output logic                    sweep_up_o,
  output logic                    lock_o
);

  logic sweep_on, at_max, at_min;

  pll_sweep_ctrl u_sweep (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .phase_lock_i (phase_lock_i),
    .at_max_i     (at_max),
    .at_min_i     (at_min),
    .sweep_on_o   (sweep_on),
    .sweep_up_o   (sweep_up_o)
  );

  pll_loop_integ #(
    .INT_W      (INT_W),
    .SWEEP_STEP (SWEEP_STEP)
  ) u_integ (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pd_valid_i (pd_valid_i),
    .pd_early_i (pd_early_i),
    .sweep_on_i (sweep_on),
    .sweep_up_i (sweep_up_o),
    .acc_o      (ctrl_word_o),
    .at_max_o   (at_max),
    .at_min_o   (at_min)
  );

  pll_lock_det #(
    .NODATA_CYC (NODATA_CYC)
  ) u_lock (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .at_max_i     (at_max),
    .at_min_i     (at_min),
    .phase_lock_i (phase_lock_i),
    .lock_o       (lock_o)
  );

  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |=> (!rst_ni || (ctrl_word_o == '0 && sweep_up_o && !lock_o))); // R1

endmodule

// File: tb/pll_lock_sweep_tb.sv
module pll_lock_sweep_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 12;
  localparam int AMAX = 2047;
  localparam int AMIN = -2048;
  localparam int STEP = 4;
  localparam int ND   = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, early = 1'b0, plock = 1'b0;
  logic signed [W-1:0] ctrl;
  logic up, lock;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_lock_sweep u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pd_valid_i(valid), .pd_early_i(early),
    .phase_lock_i(plock), .ctrl_word_o(ctrl), .sweep_up_o(up), .lock_o(lock)
  );

  // cycle model from the requirements
  int m_acc, m_cnt;
  bit m_up, m_on, m_lock;
  int mism, mism_act, mism_exp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc <= 0; m_cnt <= 0; m_up <= 1; m_on <= 1; m_lock <= 0;
    end else begin
      int s; bit lim, nd;
      s = m_acc + (valid ? (early ? 1 : -1) : 0) + (m_on ? (m_up ? STEP : -STEP) : 0);
      if (s > AMAX) s = AMAX;
      if (s < AMIN) s = AMIN;
      lim = (m_acc == AMAX) || (m_acc == AMIN);
      nd  = lim && (m_cnt == ND);
      m_lock <= plock && !nd;
      m_cnt  <= !lim ? 0 : (m_cnt == ND ? ND : m_cnt + 1);
      if (m_on && m_up && m_acc == AMAX) m_up <= 0;
      else if (m_on && !m_up && m_acc == AMIN) m_up <= 1;
      m_on  <= !plock;
      m_acc <= s;
    end
  end

  always @(negedge clk) begin
    if (rst_n && (int'(ctrl) != m_acc || up != m_up || lock != m_lock)) begin
      if (mism == 0) begin mism_act = int'(ctrl); mism_exp = m_acc; end
      mism++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_chk(input string req);
    chk(mism == 0, req, mism_act, mism_exp);
    mism = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; valid = 0; plock = 0;
    cyc(2);
    chk(ctrl == 0, "R1 ctrl in reset", int'(ctrl), 0);
    chk(up == 1, "R1 dir in reset", up, 1);
    chk(lock == 0, "R1 lock in reset", lock, 0);
    rst_n = 1;
    cyc(1);
    chk(ctrl == STEP, "R1 sweep enabled after reset", int'(ctrl), STEP);
    mism = 0;
  endtask

  task automatic t_pd_steps();
    int base;
    plock = 1; valid = 0;
    cyc(3);
    base = int'(ctrl);
    cyc(3);
    chk(int'(ctrl) == base, "R4 hold with lock and no data", int'(ctrl), base);
    chk(lock == 1, "R8 lock with phase lock", lock, 1);
    valid = 1; early = 1; cyc(5);
    chk(int'(ctrl) == base + 5, "R2 early steps", int'(ctrl), base + 5);
    early = 0; cyc(2);
    valid = 0; cyc(3);
    chk(int'(ctrl) == base + 3, "R2 late and idle", int'(ctrl), base + 3);
    for (int i = 0; i < 12; i++) begin
      valid = i[0]; early = i[1]; cyc(1);
    end
    valid = 0; cyc(1);
    chk(int'(ctrl) == base + 3, "R2 mixed pattern net zero", int'(ctrl), base + 3);
    model_chk("R2 model");
  endtask

  task automatic t_clamp_nodata();
    int g;
    plock = 1; valid = 1; early = 1;
    g = 0;
    while (int'(ctrl) != AMAX && g < 5000) begin cyc(1); g++; end
    chk(int'(ctrl) == AMAX, "R3 reach max", int'(ctrl), AMAX);
    cyc(10);
    chk(int'(ctrl) == AMAX, "R3 clamp at max", int'(ctrl), AMAX);
    chk(lock == 1, "R7 lock before 16 cycles", lock, 1);
    cyc(10);
    chk(lock == 0, "R7 lock dropped by no-data", lock, 0);
    early = 0; cyc(1);
    valid = 0;
    chk(int'(ctrl) == AMAX - 1, "R9 left limit", int'(ctrl), AMAX - 1);
    cyc(1);
    chk(lock == 1, "R9 lock returns", lock, 1);
    valid = 1; early = 0; g = 0;
    while (int'(ctrl) != AMIN && g < 6000) begin cyc(1); g++; end
    cyc(5);
    chk(int'(ctrl) == AMIN, "R3 clamp at min", int'(ctrl), AMIN);
    cyc(20);
    chk(lock == 0, "R7 no-data at min", lock, 0);
    valid = 0;
    model_chk("R7 model");
  endtask

  task automatic t_sweep();
    int g;
    plock = 0; valid = 1; early = 1;
    cyc(1);
    chk(lock == 0, "R8 lock low without phase lock", lock, 0);
    g = 0;
    while (up == 1 && g < 3000) begin cyc(1); g++; end
    chk(up == 0 && int'(ctrl) == AMAX, "R6 turn at top", int'(ctrl), AMAX);
    cyc(1);
    chk(int'(ctrl) == AMAX - STEP + 1, "R5 sweep plus detector after turn", int'(ctrl), AMAX - STEP + 1);
    early = 0; g = 0;
    while (up == 0 && g < 3000) begin cyc(1); g++; end
    chk(up == 1 && int'(ctrl) == AMIN, "R6 turn at bottom", int'(ctrl), AMIN);
    cyc(1);
    chk(int'(ctrl) == AMIN + STEP - 1, "R5 sweep minus detector", int'(ctrl), AMIN + STEP - 1);
    valid = 0; cyc(5);
    chk(int'(ctrl) == AMIN + 6 * STEP - 1, "R5 pure sweep", int'(ctrl), AMIN + 6 * STEP - 1);
    plock = 1; cyc(1);
    g = int'(ctrl);
    chk(g == AMIN + 7 * STEP - 1, "R4 last sweep step", g, AMIN + 7 * STEP - 1);
    cyc(4);
    chk(int'(ctrl) == g, "R4 sweep stopped", int'(ctrl), g);
    model_chk("R6 model");
  endtask

  initial begin
    mism = 0;
    t_reset();
    t_pd_steps();
    t_clamp_nodata();
    t_sweep();
    t_reset();
    chk(lock == 0, "R1 lock after second reset", lock, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule